// File: doc/BRIEF.md
# PHY Control-Port Handshake Master

This block drives the parallel control port of a serial-link PHY. The port takes one 20-bit control word. The low 16 bits carry a value. The four bits above carry four strobes: capture-address, capture-data, commit-write and read. The PHY answers on one acknowledge line and returns a 16-bit read value. A local command interface starts an operation with a one-cycle start pulse, a 2-bit operation code and a 16-bit value. The block then runs the strobe sequence the operation needs, and ends it with a one-cycle done pulse and an error flag.

Each strobe uses a four-phase handshake. The strobe is raised and the block polls until acknowledge is high. The strobe is then dropped and the block polls until acknowledge is low. Polling is bounded. The acknowledge line is sampled once, then once every `POLL_GAP+1` cycles, up to `POLL_LIMIT` samples per wait. A write whose value has bit 0 set is a PHY reset. For that write the commit-write strobe is raised and the operation ends at once, because a PHY in reset cannot answer.

Top module: `phycr_master`

## Requirements
- R1: After reset, `phy_ctl` is all zero, `cmd_busy`, `cmd_done` and `cmd_err` are low, and `cmd_rdata` is zero.
- R2: The control word places the value in bits 15:0 and the strobes at fixed bits: capture-address at bit 16, capture-data at bit 17, commit-write at bit 18 and read at bit 19. At most one strobe is high at any time.
- R3: An accepted start loads `cmd_value` into bits 15:0 with all strobes low. The value is held for one cycle before the first strobe rises, and stays unchanged until the operation ends.
- R4: Operation codes are 2'b00 (address: one capture-address handshake), 2'b01 (write: a capture-data handshake, then a commit-write handshake) and 2'b10 (read: one read handshake). In each handshake the strobe stays high until acknowledge is sampled high. It then drops, and the block waits for acknowledge to be sampled low.
- R5: Each wait samples `phy_ack` in its first cycle, and every `POLL_GAP+1` cycles after a miss. If `POLL_LIMIT` samples all miss, every strobe drops and the operation ends with `cmd_err` high. With the defaults (10 samples, gap 3), an address operation to a silent PHY ends with done visible 39 cycles after the start edge. An acknowledge first seen on the tenth sample still succeeds.
- R6: A read latches `phy_dout` on the sample that finds acknowledge high. `cmd_rdata` holds that value until a later read latches again.
- R7: A write whose value has bit 0 set performs the capture-data handshake, then raises commit-write and completes in that same cycle without waiting for acknowledge. Commit-write stays high until the next accepted start.
- R8: `cmd_done` is a one-cycle pulse per operation. `cmd_err` changes only with done or at an accepted start (cleared there), so it stays valid between operations.
- R9: A start while busy is ignored, and so is a start with operation code 2'b11. Neither produces a done pulse or changes `phy_ctl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle operation start |
| cmd_op | input | 2 | Operation code (00 address, 01 write, 10 read, 11 ignored) |
| cmd_value | input | 16 | Address or write value |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | 16 | PHY read data |
| phy_ctl | output | 20 | Control word: value 15:0, strobes 19:16 |
| cmd_busy | output | 1 | Operation in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | Last operation timed out |
| cmd_rdata | output | 16 | Last latched read value |

## Verification
Two events can land in the same cycle: an acknowledge that first turns up on the final poll sample, and the exhaustion of the poll budget. The bench sets up both cases with a PHY model whose acknowledge latency is programmable. A latency of 36 cycles puts the acknowledge exactly on the tenth sample, and that operation must finish without error. A latency of 37 misses that sample, and the operation must time out. A second collision is a start arriving while the block is busy. The bench fires it in the middle of an operation and counts strobe edges and done pulses to show that it had no effect. A behavioural reference model built on a strobe queue is compared with the outputs on every cycle.

// File: rtl/phycr_pkg.sv
package phycr_pkg;
    localparam int DW    = 16;
    localparam int STB_N = 4;
    localparam int CW    = DW + STB_N;

    // strobe index inside the strobe field (bit DW+index of the control word)
    localparam int B_ADDR = 0;
    localparam int B_DATA = 1;
    localparam int B_WR   = 2;
    localparam int B_RD   = 3;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WHI,
        ST_WLO
    } st_e;

    typedef struct packed {
        st_e              st;
        op_e              op;
        logic             step;
        logic             rst_wr;
        logic [STB_N-1:0] stb;
        logic [DW-1:0]    data;
        logic [DW-1:0]    rd;
        logic             done;
        logic             err;
    } mst_s;
endpackage

// File: rtl/phycr_step.sv
module phycr_step
    import phycr_pkg::*;
(
    input  op_e              op,
    input  logic             step,
    output logic [STB_N-1:0] stb,
    output logic             last,
    output logic             wr_phase
);
    always_comb begin
        stb      = '0;
        last     = 1'b1;
        wr_phase = 1'b0;
        case (op)
            OP_ADDR:  stb[B_ADDR] = 1'b1;
            OP_WRITE: begin
                if (!step) begin
                    stb[B_DATA] = 1'b1;
                    last        = 1'b0;
                end else begin
                    stb[B_WR]   = 1'b1;
                    wr_phase    = 1'b1;
                end
            end
            OP_READ:  stb[B_RD] = 1'b1;
            default:  stb = '0;
        endcase
    end
endmodule

// File: rtl/phycr_poll.sv
module phycr_poll #(
    parameter int LIMIT = 10,
    parameter int GAP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic want,
    input  logic ack,
    output logic hit,
    output logic expire
);
    localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam int GAP_W = (GAP < 1) ? 1 : $clog2(GAP + 1);

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [CNT_W-1:0] cnt;
    } poll_s;

    poll_s q, d;
    logic  sample;

    assign sample = en && (q.gap == '0);
    assign hit    = sample && (ack == want);
    assign expire = sample && (ack != want) && (q.cnt == CNT_W'(LIMIT - 1));

    always_comb begin
        d = q;
        if (!en || hit || expire) begin
            d.gap = '0;
            d.cnt = '0;
        end else if (sample) begin
            d.gap = GAP_W'(GAP);
            d.cnt = q.cnt + CNT_W'(1);
        end else begin
            d.gap = q.gap - GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: the sample budget is never exceeded
    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(LIMIT - 1));

    // R5: a miss always restarts the gap timer before the next sample
    p_gap_after_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !hit && !expire && (GAP > 0)) |=> (q.gap != '0));
endmodule

// File: rtl/phycr_master.sv
module phycr_master
    import phycr_pkg::*;
#(
    parameter int POLL_LIMIT = 10,
    parameter int POLL_GAP   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [1:0]    cmd_op,
    input  logic [15:0]   cmd_value,
    input  logic          phy_ack,
    input  logic [15:0]   phy_dout,
    output logic [19:0]   phy_ctl,
    output logic          cmd_busy,
    output logic          cmd_done,
    output logic          cmd_err,
    output logic [15:0]   cmd_rdata
);
    mst_s             q, d;
    logic [STB_N-1:0] step_stb;
    logic             step_last;
    logic             step_wr;
    logic             waiting;
    logic             hit;
    logic             expire;

    phycr_step u_step (
        .op       (q.op),
        .step     (q.step),
        .stb      (step_stb),
        .last     (step_last),
        .wr_phase (step_wr)
    );

    assign waiting = (q.st == ST_WHI) || (q.st == ST_WLO);

    phycr_poll #(
        .LIMIT (POLL_LIMIT),
        .GAP   (POLL_GAP)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (waiting),
        .want   (q.st == ST_WHI),
        .ack    (phy_ack),
        .hit    (hit),
        .expire (expire)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cmd_start && (op_e'(cmd_op) != OP_RSVD)) begin
                    d.st     = ST_SETUP;
                    d.op     = op_e'(cmd_op);
                    d.step   = 1'b0;
                    d.rst_wr = cmd_value[0];
                    d.stb    = '0;
                    d.data   = cmd_value;
                    d.err    = 1'b0;
                end
            end
            ST_SETUP: begin
                d.stb = step_stb;
                if (step_wr && q.rst_wr) begin
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.st   = ST_WHI;
                end
            end
            ST_WHI: begin
                if (hit) begin
                    if (q.op == OP_READ) d.rd = phy_dout;
                    d.stb = '0;
                    d.st  = ST_WLO;
                end else if (expire) begin
                    d.stb  = '0;
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            ST_WLO: begin
                if (hit) begin
                    if (step_last) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.step = 1'b1;
                        d.st   = ST_SETUP;
                    end
                end else if (expire) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign phy_ctl   = {q.stb, q.data};
    assign cmd_busy  = (q.st != ST_IDLE);
    assign cmd_done  = q.done;
    assign cmd_err   = q.err;
    assign cmd_rdata = q.rd;

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_ctl[19:16]));

    p_strobe_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|phy_ctl[19:16]) |-> $past(cmd_busy));

    p_drop_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(|phy_ctl[19:16]) |-> ($past(phy_ack) || cmd_done));

    p_rdata_only_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cmd_rdata) |-> $past(cmd_busy));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_err) |-> cmd_done);

    p_value_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_busy |=> $stable(phy_ctl[15:0]));
endmodule

// File: tb/phycr_master_test.sv
module phycr_master_test;
    localparam int LIM = 10;
    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_value = 16'h0;
    logic        phy_ack;
    logic [15:0] phy_dout;
    logic [19:0] phy_ctl;
    logic        cmd_busy, cmd_done, cmd_err;
    logic [15:0] cmd_rdata;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit over = 0;

    always #5 clk = ~clk;

    phycr_master #(.POLL_LIMIT(LIM), .POLL_GAP(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .cmd_value(cmd_value), .phy_ack(phy_ack), .phy_dout(phy_dout),
        .phy_ctl(phy_ctl), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .cmd_rdata(cmd_rdata));

    // ---------------- PHY model ----------------
    int          lat_hi = 2, lat_lo = 2;
    bit          dead = 0, stuck = 0;
    logic        ack_q = 1'b0;
    int          hi_cnt = 0, lo_cnt = 0;
    logic [15:0] cap_addr = 16'h0;
    int          rise_n [4];
    logic [3:0]  stb_prev = 4'h0;

    initial for (int i = 0; i < 4; i++) rise_n[i] = 0;

    always @(posedge clk) begin
        if (|phy_ctl[19:16]) begin
            hi_cnt = hi_cnt + 1;
            lo_cnt = 0;
            if (hi_cnt >= lat_hi) ack_q <= 1'b1;
        end else begin
            lo_cnt = lo_cnt + 1;
            hi_cnt = 0;
            if (lo_cnt >= lat_lo) ack_q <= 1'b0;
        end
        if (phy_ctl[16]) cap_addr <= phy_ctl[15:0];
        for (int i = 0; i < 4; i++)
            if (phy_ctl[16+i] && !stb_prev[i]) rise_n[i]++;
        stb_prev <= phy_ctl[19:16];
    end

    assign phy_ack  = dead ? 1'b0 : (stuck ? 1'b1 : ack_q);
    assign phy_dout = cap_addr ^ 16'h5A3C;

    // ---------------- reference model ----------------
    int          ph = 0, polls = 0, wait_c = 0;
    int          sq[$];
    bit          m_rstwr = 0;
    logic [19:0] m_ctl = '0;
    logic [15:0] m_rd = '0;
    logic        m_done = 0, m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; polls = 0; wait_c = 0; sq.delete();
            m_ctl = '0; m_rd = '0; m_done = 0; m_err = 0;
        end else begin
            m_done = 0;
            if (ph == 0) begin
                if (cmd_start && cmd_op != 2'b11) begin
                    sq.delete();
                    case (cmd_op)
                        2'b00: sq.push_back(16);
                        2'b01: begin sq.push_back(17); sq.push_back(18); end
                        default: sq.push_back(19);
                    endcase
                    m_ctl = {4'h0, cmd_value};
                    m_rstwr = cmd_value[0];
                    m_err = 0;
                    ph = 1;
                end
            end else if (ph == 1) begin
                m_ctl[sq[0]] = 1'b1;
                if (sq[0] == 18 && m_rstwr) begin
                    m_done = 1; ph = 0;
                end else begin
                    ph = 2; polls = 0; wait_c = 0;
                end
            end else begin
                if (wait_c > 0) wait_c--;
                else if (phy_ack == (ph == 2)) begin
                    if (ph == 2) begin
                        if (sq[0] == 19) m_rd = phy_dout;
                        m_ctl[19:16] = 4'h0;
                        ph = 3; polls = 0;
                    end else begin
                        void'(sq.pop_front());
                        if (sq.size() == 0) begin m_done = 1; ph = 0; end
                        else ph = 1;
                    end
                end else begin
                    polls++;
                    if (polls == LIM) begin
                        m_ctl[19:16] = 4'h0;
                        m_done = 1; m_err = 1; ph = 0;
                    end else wait_c = GAP;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle compare against the model
    always @(negedge clk) begin
        if (rst_n && !over) begin
            chk(phy_ctl === m_ctl, "R2 control word", 32'(phy_ctl), 32'(m_ctl));
            chk(cmd_done === m_done, "R8 done", 32'(cmd_done), 32'(m_done));
            chk(cmd_err === m_err, "R8 err", 32'(cmd_err), 32'(m_err));
            chk(cmd_rdata === m_rd, "R6 rdata", 32'(cmd_rdata), 32'(m_rd));
            chk(cmd_busy === (ph != 0), "R9 busy", 32'(cmd_busy), 32'(ph != 0));
        end
    end

    task automatic finish_run();
        over = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !over) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic run(input logic [1:0] op, input logic [15:0] v, output int n, output logic e);
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = op; cmd_value = v;
        @(negedge clk);
        cmd_start = 1'b0; n = 1;
        while (!cmd_done) begin @(negedge clk); n++; end
        e = cmd_err;
        @(negedge clk);
        chk(!cmd_done, "R8 done one cycle", 32'(cmd_done), 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int          n;
        logic        e;
        int          r0, r1, r2, r3;
        bit          seen_done;
        repeat (3) @(negedge clk);
        chk(phy_ctl == 20'h0 && !cmd_busy && !cmd_done && !cmd_err && cmd_rdata == 16'h0,
            "R1 reset state", 32'(phy_ctl), 0);
        rst_n = 1'b1;
        idle(2);

        // R4 address then R6 read
        r0 = rise_n[0];
        run(2'b00, 16'h2003, n, e);
        chk(e == 1'b0, "R4 address no error", 32'(e), 0);
        chk(cap_addr == 16'h2003, "R2 address captured via bit 16", 32'(cap_addr), 32'h2003);
        chk(rise_n[0] == r0 + 1, "R4 one capture-address strobe", rise_n[0], r0 + 1);
        idle(5);
        run(2'b10, 16'h0, n, e);
        chk(cmd_rdata == (16'h2003 ^ 16'h5A3C), "R6 read data", 32'(cmd_rdata), 32'(16'h2003 ^ 16'h5A3C));
        idle(5);

        // R4 normal write: data then write strobe
        r1 = rise_n[1]; r2 = rise_n[2];
        run(2'b01, 16'h0010, n, e);
        chk(rise_n[1] == r1 + 1 && rise_n[2] == r2 + 1, "R4 write strobe pair",
            rise_n[1] + rise_n[2], r1 + r2 + 2);
        chk(cmd_rdata == (16'h2003 ^ 16'h5A3C), "R6 rdata held after write", 32'(cmd_rdata),
            32'(16'h2003 ^ 16'h5A3C));
        idle(5);

        // R9 start while busy is ignored
        r3 = rise_n[3];
        @(negedge clk); cmd_start = 1; cmd_op = 2'b00; cmd_value = 16'h1111;
        @(negedge clk); cmd_start = 0;
        idle(2);
        cmd_start = 1; cmd_op = 2'b10; cmd_value = 16'h2222;
        @(negedge clk); cmd_start = 0;
        while (!cmd_done) @(negedge clk);
        seen_done = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (cmd_done) seen_done = 1; end
        chk(!seen_done && rise_n[3] == r3, "R9 busy start ignored", rise_n[3], r3);
        chk(phy_ctl[15:0] == 16'h1111, "R3 value kept", 32'(phy_ctl[15:0]), 32'h1111);

        // R9 reserved op ignored
        @(negedge clk); cmd_start = 1; cmd_op = 2'b11; cmd_value = 16'hBEEF;
        @(negedge clk); cmd_start = 0;
        seen_done = 0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (cmd_done || cmd_busy) seen_done = 1; end
        chk(!seen_done && phy_ctl == 20'h01111, "R9 reserved op ignored", 32'(phy_ctl), 32'h01111);

        // R5 silent PHY timeout and timing
        dead = 1;
        run(2'b00, 16'h0042, n, e);
        chk(e == 1'b1, "R5 timeout error", 32'(e), 1);
        chk(n == 3 + (LIM - 1) * (GAP + 1), "R5 timeout cycle", n, 3 + (LIM - 1) * (GAP + 1));
        chk(phy_ctl[19:16] == 4'h0, "R5 strobes dropped", 32'(phy_ctl[19:16]), 0);
        idle(6);
        chk(cmd_err == 1'b1, "R8 err held", 32'(cmd_err), 1);
        dead = 0;
        @(negedge clk); cmd_start = 1; cmd_op = 2'b00; cmd_value = 16'h0044;
        @(negedge clk); cmd_start = 0;
        chk(cmd_err == 1'b0, "R8 err cleared at start", 32'(cmd_err), 0);
        while (!cmd_done) @(negedge clk);
        idle(8);

        // R5 boundary: ack on last sample vs one later
        lat_hi = 36;
        run(2'b00, 16'h0050, n, e);
        chk(e == 1'b0, "R5 ack on final sample", 32'(e), 0);
        idle(8);
        lat_hi = 37;
        run(2'b00, 16'h0051, n, e);
        chk(e == 1'b1, "R5 ack one sample late", 32'(e), 1);
        lat_hi = 2;
        idle(8);

        // R5 stuck-high ack: low wait times out
        stuck = 1;
        run(2'b10, 16'h0, n, e);
        chk(e == 1'b1, "R5 low wait timeout", 32'(e), 1);
        stuck = 0;
        idle(8);

        // R7 reset write
        r2 = rise_n[2];
        run(2'b01, 16'h0001, n, e);
        chk(e == 1'b0, "R7 reset write no error", 32'(e), 0);
        idle(20);
        chk(phy_ctl[18] == 1'b1 && rise_n[2] == r2 + 1, "R7 commit strobe held", 32'(phy_ctl), 32'h40001);

        // R1 reset again
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        chk(phy_ctl == 20'h0 && !cmd_busy && !cmd_err && cmd_rdata == 16'h0, "R1 mid-run reset",
            32'(phy_ctl), 0);
        rst_n = 1;
        idle(3);
        finish_run();
    end
endmodule